// File: doc/BRIEF.md
# Sticky Fault Cause Register

This block holds a single 32-bit status word that remembers why a processor took a usage fault, a bus fault or a memory-protection fault. Each cause is one flag bit. A one-cycle pulse on the matching bit of the hardware event vector sets the flag. The flag then stays set until software writes a one to that bit. Bit positions that carry no cause always read as zero.

The word is split into three sub-registers that software can reach on their own or together. The usage-fault causes sit in the upper halfword. The bus-fault causes sit in byte 1 and the memory-protection causes sit in byte 0. A small request bus carries the lane offset, byte strobes, a write flag, write data and a privilege bit. The block answers every request one cycle later with a response-valid pulse, an error bit and lane-aligned read data. Only privileged requests of a supported size and offset take effect.

Top module: `fault_cause_regs`

## Requirements
- R1: After a synchronous reset every flag is 0, and rsp_vld, rsp_err and rsp_rdata are 0.
- R2: A 1 on a live position of fault_evt sets that flag at the next clock edge. The flag stays 1 after the event drops, until software clears it.
- R3: A legal privileged write clears each flag whose bit is 1 in bus_wdata and lies inside the strobed lanes. Bits written as 0, and bits outside the strobed lanes, keep their value.
- R4: If an event sets a bit in the same cycle that a write clears it, the bit ends up 1.
- R5: Positions 31:26, 23:20, 14, 6 and 2 always read 0, whatever the event or write data.
- R6: Legal access shapes, given as (bus_off, bus_strb), are (0, 1111) for the whole word, (0, 0001) for byte 0, (0, 0011) for bits 15:0, (1, 0010) for byte 1 and (2, 1100) for bits 31:16. A read returns the flags in their own bit positions with the unstrobed lanes at 0. The response comes one cycle after the request, marked by rsp_vld.
- R7: A request with bus_priv low gets rsp_err=1 and rsp_rdata=0, and leaves every flag unchanged.
- R8: A privileged request with any other (offset, strobe) pair gets rsp_err=1 and rsp_rdata=0, and leaves every flag unchanged.
- R9: The live positions are as follows. Usage-fault causes: 25 divide by zero, 24 unaligned, 19 no coprocessor, 18 bad PC load, 17 bad state, 16 undefined opcode. Bus-fault causes: 15 address valid, 13 lazy FP save, 12 entry stacking, 11 return unstacking, 10 imprecise, 9 precise, 8 fetch. Memory-protection causes: 7 address valid, 5 lazy FP save, 4 stacking, 3 unstacking, 1 data access, 0 fetch. Together these give the mask 0x030FBFBB.
- R10: A write request returns rsp_vld=1, rsp_err=0 and rsp_rdata=0 when it is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 = write (clear), 0 = read |
| bus_priv | input | 1 | Requester is privileged |
| bus_off | input | 2 | Byte offset inside the word |
| bus_strb | input | 4 | Byte-lane strobes |
| bus_wdata | input | 32 | Write data, lane aligned; ones clear flags |
| fault_evt | input | 32 | Hardware fault event pulses, one per flag position |
| rsp_vld | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request was refused |
| rsp_rdata | output | 32 | Read data, lane aligned |

## Verification
The bench builds the block with the default live-bit mask. Every one of the 32 per-bit generate branches is therefore elaborated, both the sticky flags and the tied-off positions. Random full-width event and write-data patterns, mixed with legal and illegal offset and strobe pairs, reach every live and reserved bit through each of the five access shapes. Directed cases cover the set-against-clear collision, refused requests and lane isolation.

// File: rtl/fault_cause_pkg.sv
package fault_cause_pkg;

    localparam int REG_W  = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = REG_W / LANE_W;
    localparam int OFF_W  = $clog2(LANES);

    // Usage-fault causes (upper halfword)
    localparam int B_DIVZ   = 25;
    localparam int B_UNALGN = 24;
    localparam int B_NOCOP  = 19;
    localparam int B_BADPC  = 18;
    localparam int B_BADST  = 17;
    localparam int B_UNDEF  = 16;
    // Bus-fault causes (byte 1)
    localparam int B_BADR_V = 15;
    localparam int B_BLAZY  = 13;
    localparam int B_BSTK   = 12;
    localparam int B_BUNSTK = 11;
    localparam int B_IMPR   = 10;
    localparam int B_PREC   = 9;
    localparam int B_IFETCH = 8;
    // Memory-protection causes (byte 0)
    localparam int B_MADR_V = 7;
    localparam int B_MLAZY  = 5;
    localparam int B_MSTK   = 4;
    localparam int B_MUNSTK = 3;
    localparam int B_DACC   = 1;
    localparam int B_IACC   = 0;

    function automatic logic [REG_W-1:0] live_mask_f();
        logic [REG_W-1:0] m;
        m = '0;
        m[B_DIVZ]   = 1'b1; m[B_UNALGN] = 1'b1; m[B_NOCOP]  = 1'b1;
        m[B_BADPC]  = 1'b1; m[B_BADST]  = 1'b1; m[B_UNDEF]  = 1'b1;
        m[B_BADR_V] = 1'b1; m[B_BLAZY]  = 1'b1; m[B_BSTK]   = 1'b1;
        m[B_BUNSTK] = 1'b1; m[B_IMPR]   = 1'b1; m[B_PREC]   = 1'b1;
        m[B_IFETCH] = 1'b1;
        m[B_MADR_V] = 1'b1; m[B_MLAZY]  = 1'b1; m[B_MSTK]   = 1'b1;
        m[B_MUNSTK] = 1'b1; m[B_DACC]   = 1'b1; m[B_IACC]   = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] LIVE_MASK = live_mask_f();

    typedef enum logic [2:0] {
        SHP_NONE,
        SHP_WORD,
        SHP_MEM_B,
        SHP_LOW_H,
        SHP_BUS_B,
        SHP_USG_H
    } shape_e;

    typedef struct packed {
        logic             legal;
        logic             err;
        logic [REG_W-1:0] lanes;
        logic [REG_W-1:0] clr;
    } decode_t;

    typedef struct packed {
        logic             vld;
        logic             err;
        logic [REG_W-1:0] rdata;
    } resp_t;

    // Expand byte strobes to a bit mask
    function automatic logic [REG_W-1:0] lane_bits(input logic [LANES-1:0] strb);
        logic [REG_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*LANE_W +: LANE_W] = {LANE_W{strb[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/fault_access_decode.sv
module fault_access_decode
    import fault_cause_pkg::*;
(
    input  logic             req,
    input  logic             wr,
    input  logic             priv,
    input  logic [OFF_W-1:0] off,
    input  logic [LANES-1:0] strb,
    input  logic [REG_W-1:0] wdata,
    output decode_t          dec
);

    shape_e shape;

    always_comb begin
        unique case ({off, strb})
            {2'd0, 4'b1111}: shape = SHP_WORD;
            {2'd0, 4'b0001}: shape = SHP_MEM_B;
            {2'd0, 4'b0011}: shape = SHP_LOW_H;
            {2'd1, 4'b0010}: shape = SHP_BUS_B;
            {2'd2, 4'b1100}: shape = SHP_USG_H;
            default:         shape = SHP_NONE;
        endcase
    end

    always_comb begin
        dec.lanes = lane_bits(strb);
        dec.legal = req && priv && (shape != SHP_NONE);
        dec.err   = req && !dec.legal;
        dec.clr   = (dec.legal && wr) ? (wdata & dec.lanes) : '0;
    end

endmodule

// File: rtl/fault_flag_bank.sv
module fault_flag_bank #(
    parameter int                W    = 32,
    parameter logic [W-1:0]      LIVE = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    output logic [W-1:0] flags
);

    logic unused_rsv;
    assign unused_rsv = ^((set_v | clr_v) & ~LIVE);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (LIVE[i]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)           bit_q <= 1'b0;
                else if (set_v[i]) bit_q <= 1'b1;   // event beats clear
                else if (clr_v[i]) bit_q <= 1'b0;
            end
            assign flags[i] = bit_q;
        end else begin : g_rsv
            assign flags[i] = 1'b0;
        end
    end

endmodule

// File: rtl/fault_resp_reg.sv
module fault_resp_reg
    import fault_cause_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             wr,
    input  decode_t          dec,
    input  logic [REG_W-1:0] flags,
    output resp_t            rsp
);

    resp_t rsp_d;

    always_comb begin
        rsp_d.vld   = req;
        rsp_d.err   = dec.err;
        rsp_d.rdata = (dec.legal && !wr) ? (flags & dec.lanes) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) rsp <= '0;
        else     rsp <= rsp_d;
    end

endmodule

// File: rtl/fault_cause_regs.sv
module fault_cause_regs
    import fault_cause_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_req,
    input  logic             bus_wr,
    input  logic             bus_priv,
    input  logic [OFF_W-1:0] bus_off,
    input  logic [LANES-1:0] bus_strb,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic [REG_W-1:0] fault_evt,
    output logic             rsp_vld,
    output logic             rsp_err,
    output logic [REG_W-1:0] rsp_rdata
);

    decode_t          dec;
    resp_t            rsp;
    logic [REG_W-1:0] flags_q;

    fault_access_decode u_dec (
        .req   (bus_req),
        .wr    (bus_wr),
        .priv  (bus_priv),
        .off   (bus_off),
        .strb  (bus_strb),
        .wdata (bus_wdata),
        .dec   (dec)
    );

    fault_flag_bank #(
        .W    (REG_W),
        .LIVE (LIVE_MASK)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .set_v (fault_evt),
        .clr_v (dec.clr),
        .flags (flags_q)
    );

    fault_resp_reg u_rsp (
        .clk   (clk),
        .rst   (rst),
        .req   (bus_req),
        .wr    (bus_wr),
        .dec   (dec),
        .flags (flags_q),
        .rsp   (rsp)
    );

    assign rsp_vld   = rsp.vld;
    assign rsp_err   = rsp.err;
    assign rsp_rdata = rsp.rdata;

endmodule

// File: rtl/fault_cause_chk.sv
module fault_cause_chk
    import fault_cause_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_req,
    input logic             bus_wr,
    input logic             bus_priv,
    input logic [REG_W-1:0] fault_evt,
    input logic [REG_W-1:0] flags_q,
    input logic             rsp_vld,
    input logic             rsp_err,
    input logic [REG_W-1:0] rsp_rdata
);

    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && bus_wr) |=> (($past(flags_q) & ~flags_q) == '0));

    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|(fault_evt & LIVE_MASK)) |=>
            ((flags_q & $past(fault_evt) & LIVE_MASK) == ($past(fault_evt) & LIVE_MASK)));

    a_r5_rsv_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_vld |-> ((rsp_rdata & ~LIVE_MASK) == '0));

    a_r6_resp_next: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> rsp_vld);

    a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> (!rsp_vld && !rsp_err));

    a_r7_unpriv: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_priv && (fault_evt == '0)) |=> (rsp_err && (flags_q == $past(flags_q))));

    a_r8_err_nodata: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == '0));

endmodule

bind fault_cause_regs fault_cause_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_priv  (bus_priv),
    .fault_evt (fault_evt),
    .flags_q   (flags_q),
    .rsp_vld   (rsp_vld),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
);

// File: tb/fault_cause_regs_tb.sv
module fault_cause_regs_tb_top;

    localparam logic [31:0] LIVE = 32'h030F_BFBB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_wr = 1'b0, bus_priv = 1'b0;
    logic [1:0]  bus_off = '0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_wdata = '0, fault_evt = '0;
    logic        rsp_vld, rsp_err;
    logic [31:0] rsp_rdata;

    int total = 0;
    int bad   = 0;
    logic [31:0] m_flags = '0;

    always #10 clk = ~clk;

    fault_cause_regs dut_i (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_priv(bus_priv),
        .bus_off(bus_off), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
        .fault_evt(fault_evt),
        .rsp_vld(rsp_vld), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    function automatic logic shape_ok(input logic [1:0] o, input logic [3:0] s);
        return (o == 2'd0 && (s == 4'b1111 || s == 4'b0001 || s == 4'b0011)) ||
               (o == 2'd1 && s == 4'b0010) || (o == 2'd2 && s == 4'b1100);
    endfunction

    function automatic logic [31:0] lanes_of(input logic [3:0] s);
        return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // One bus cycle from a negedge, checked at the following negedge
    task automatic cyc(input logic r, input logic w, input logic p,
                       input logic [1:0] o, input logic [3:0] s,
                       input logic [31:0] d, input logic [31:0] e, input string tag);
        logic legal, x_err;
        logic [31:0] x_data, nxt;
        legal  = r && p && shape_ok(o, s);
        x_err  = r && !legal;
        x_data = (legal && !w) ? (m_flags & lanes_of(s)) : 32'h0;
        nxt    = (legal && w) ? (m_flags & ~(d & lanes_of(s))) : m_flags;
        nxt    = nxt | (e & LIVE);
        bus_req = r; bus_wr = w; bus_priv = p; bus_off = o; bus_strb = s;
        bus_wdata = d; fault_evt = e;
        @(posedge clk);
        @(negedge clk);
        m_flags = nxt;
        bus_req = 1'b0; fault_evt = '0;
        if (r) begin
            check(tag, "vld", {31'b0, rsp_vld}, 32'd1);
            check(tag, "err", {31'b0, rsp_err}, {31'b0, x_err});
            check(tag, "rdata", rsp_rdata, x_data);
        end else begin
            check(tag, "idle vld", {31'b0, rsp_vld}, 32'd0);
        end
    endtask

    task automatic rd_word(input string tag);
        cyc(1'b1, 1'b0, 1'b1, 2'd0, 4'b1111, 32'h0, 32'h0, tag);
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog: got hang expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1", "vld", {31'b0, rsp_vld}, 32'd0);
        check("R1", "err", {31'b0, rsp_err}, 32'd0);
        check("R1", "rdata", rsp_rdata, 32'd0);
        rst = 1'b0;
        rd_word("R1");

        // R2/R5/R9: all events once, then idle, then read
        cyc(1'b0, 1'b0, 1'b1, 2'd0, 4'b0, 32'h0, 32'hFFFF_FFFF, "R2");
        cyc(1'b0, 1'b0, 1'b1, 2'd0, 4'b0, 32'h0, 32'h0, "R2");
        rd_word("R2");
        rd_word("R5");
        check("R9", "model mask", m_flags, 32'h030F_BFBB);

        // R6: every legal shape reads lanes in place
        cyc(1'b1, 1'b0, 1'b1, 2'd0, 4'b0001, 32'h0, 32'h0, "R6");
        cyc(1'b1, 1'b0, 1'b1, 2'd0, 4'b0011, 32'h0, 32'h0, "R6");
        cyc(1'b1, 1'b0, 1'b1, 2'd1, 4'b0010, 32'h0, 32'h0, "R6");
        cyc(1'b1, 1'b0, 1'b1, 2'd2, 4'b1100, 32'h0, 32'h0, "R6");

        // R3: write 0s leaves, write 1 clears, lanes isolate
        cyc(1'b1, 1'b1, 1'b1, 2'd0, 4'b1111, 32'h0, 32'h0, "R10");
        rd_word("R3");
        cyc(1'b1, 1'b1, 1'b1, 2'd0, 4'b1111, 32'h0000_0001, 32'h0, "R3");
        rd_word("R3");
        cyc(1'b1, 1'b1, 1'b1, 2'd1, 4'b0010, 32'hFFFF_FFFF, 32'h0, "R3");
        rd_word("R3");
        check("R3", "lane clear", m_flags, 32'h030F_00BA);

        // R4: set and clear collide on bit 25
        cyc(1'b1, 1'b1, 1'b1, 2'd0, 4'b1111, 32'hFFFF_FFFF, 32'h0200_0000, "R4");
        rd_word("R4");
        check("R4", "collision", m_flags, 32'h0200_0000);

        // R7: unprivileged write and read refused
        cyc(1'b1, 1'b1, 1'b0, 2'd0, 4'b1111, 32'hFFFF_FFFF, 32'h0, "R7");
        cyc(1'b1, 1'b0, 1'b0, 2'd0, 4'b1111, 32'h0, 32'h0, "R7");
        rd_word("R7");

        // R8: bad shapes refused
        cyc(1'b1, 1'b1, 1'b1, 2'd1, 4'b1111, 32'hFFFF_FFFF, 32'h0, "R8");
        cyc(1'b1, 1'b1, 1'b1, 2'd3, 4'b1000, 32'hFFFF_FFFF, 32'h0, "R8");
        cyc(1'b1, 1'b0, 1'b1, 2'd0, 4'b0100, 32'h0, 32'h0, "R8");
        rd_word("R8");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic r, w, p;
            logic [1:0] o;
            logic [3:0] s;
            int k;
            r = ($urandom % 2) == 0;
            w = ($urandom % 3) == 0;
            p = ($urandom % 10) != 0;
            k = $urandom % 7;
            case (k)
                0: begin o = 2'd0; s = 4'b1111; end
                1: begin o = 2'd0; s = 4'b0001; end
                2: begin o = 2'd0; s = 4'b0011; end
                3: begin o = 2'd1; s = 4'b0010; end
                4: begin o = 2'd2; s = 4'b1100; end
                default: begin o = 2'($urandom); s = 4'($urandom); end
            endcase
            cyc(r, w, p, o, s, $urandom, $urandom & $urandom & $urandom, "R6");
        end
        rd_word("R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule